// File: doc/BRIEF.md
# Timer Interrupt Router

This block sits behind a bank of timer comparators and turns each channel's one-cycle match strobe into an interrupt. Every channel carries a 64-bit configuration word and a 64-bit message word. Depending on the configuration, a match does one of three things. It can pulse one interrupt line for a single cycle (edge delivery). It can hold one interrupt line high and latch a per-channel status bit (level delivery). Or it can emit a message-signalled interrupt whose address and data come from the channel's message word.

Software reaches the block through masked configuration writes, masked message writes and a write-one-to-clear status write. On each configuration write the block checks the requested line against a read-only mask of permitted lines and resets a route that is not permitted. When a new configuration makes a latched level interrupt meaningless, the block withdraws that interrupt on its own. All outputs are registered.

Top module: `timer_irq_router`

## Requirements
- R1: After reset every channel's configuration reads the read-only permitted-lines mask in bits 63:32 (lines 24 to 31 when there are 32 or more lines, the top four lines when there are 20 to 31, none below 20), with bit 4 (periodic-capable) and bit 15 (message-capable) set and all other bits zero. For 24 lines this gives 64'h00F00000_00008010. Status, lines and message outputs are zero.
- R2: A match on a channel whose enable bit (bit 2) is 0 drives no line, sets no status and sends no message.
- R3: A match on a channel whose status bit is already set changes nothing.
- R4: Message delivery is chosen when bits 14 (message enable) and 15 (message-capable) are both 1. A match then raises msg_valid_o for exactly one cycle, the cycle after the match, with address equal to message bits 63:32 and data equal to bits 31:0, and drives no line.
- R5: The route field is configuration bits 13:9 and selects line_o[route]. A route of 0, or message delivery, drives no line.
- R6: With bit 1 equal to 0 (edge), a match raises line_o[route] for exactly one cycle, the cycle after the match.
- R7: With bit 1 equal to 1 (level), a match sets the channel's status bit and holds line_o[route] high from the next cycle until the status bit clears.
- R8: On each configuration write, a nonzero route whose bit in the permitted-lines mask is 0 is replaced by 0.
- R9: A configuration write that clears the enable bit, selects message or edge delivery, or changes the effective route clears the channel's status bit and drops its level line. Other writes leave the status bit set.
- R10: A status write clears each status bit whose write data bit is 1 and drops the matching level line. Bits written as 0 are kept.
- R11: Configuration writes update only the bits selected by the write mask, and among those only bits 1, 2, 3, 6 and 9 to 14. Bits 63:32, 15, 5 and 4 keep their values, and bit 8 (and every other bit) stays 0.
- R12: When a status clear (R9 or R10) and a level match hit the same channel in the same cycle, the clear wins and the status bit ends at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| match_i | input | NUM_CH | Per-channel comparator match strobe |
| cfg_we_i | input | NUM_CH | Per-channel configuration write strobe |
| cfg_wdata_i | input | 64 | Configuration write data |
| cfg_wmask_i | input | 64 | Configuration write bit mask |
| msg_we_i | input | NUM_CH | Per-channel message word write strobe |
| msg_wdata_i | input | 64 | Message write data |
| msg_wmask_i | input | 64 | Message write bit mask |
| sts_we_i | input | 1 | Status write-one-to-clear strobe |
| sts_wdata_i | input | NUM_CH | Status bits to clear |
| line_o | output | NUM_LINES | Interrupt line outputs |
| status_o | output | NUM_CH | Latched level status bits |
| cfg_o | output | NUM_CH*64 | Configuration words, channel 0 in the low bits |
| msg_valid_o | output | NUM_CH | Message interrupt strobe per channel |
| msg_addr_o | output | NUM_CH*32 | Message address per channel, zero when not valid |
| msg_data_o | output | NUM_CH*32 | Message data per channel, zero when not valid |

## Verification
Every result of this block comes one clock after the stimulus that causes it. An edge pulse, a message strobe, a status set or clear, a level line change and a configuration update all show at the first rising edge after the match or write, and the pulse and strobe fall again one edge later. The bench drives each stimulus on a falling edge and lets a behavioural model advance by one cycle. It then samples every output on the next falling edge, so each comparison lands in the cycle the result is due, and the idle cycle after it confirms that one-cycle results have dropped while level results hold.

// File: rtl/tir_pkg.sv
package tir_pkg;
  localparam int CFG_W      = 64;
  localparam int RT_W       = 5;
  localparam int B_LEVEL    = 1;
  localparam int B_ENABLE   = 2;
  localparam int B_PERMODE  = 3;
  localparam int B_PERCAP   = 4;
  localparam int B_VALSET   = 6;
  localparam int RT_LO      = 9;
  localparam int RT_HI      = RT_LO + RT_W - 1;
  localparam int B_MSGEN    = 14;
  localparam int B_MSGCAP   = 15;
  localparam int PERMIT_LO  = 32;

  localparam logic [CFG_W-1:0] WRITABLE =
      (64'd1 << B_LEVEL) | (64'd1 << B_ENABLE) | (64'd1 << B_PERMODE) |
      (64'd1 << B_VALSET) | (64'h1F << RT_LO) | (64'd1 << B_MSGEN);

  function automatic logic [31:0] permit_mask(input int lines);
    if (lines >= 32)      return 32'hFF00_0000;
    else if (lines >= 20) return 32'hF << (lines - 4);
    else                  return 32'h0;
  endfunction

  function automatic logic [CFG_W-1:0] cfg_reset(input int lines);
    logic [CFG_W-1:0] v;
    v = {permit_mask(lines), 32'h0};
    v[B_PERCAP] = 1'b1;
    v[B_MSGCAP] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/tir_cfg_reg.sv
module tir_cfg_reg
  import tir_pkg::*;
#(
  parameter int NUM_LINES = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we_i,
  input  logic [CFG_W-1:0] wdata_i,
  input  logic [CFG_W-1:0] wmask_i,
  output logic [CFG_W-1:0] cfg_o,
  output logic             en_o,
  output logic             lvl_o,
  output logic             msgm_o,
  output logic [RT_W-1:0]  rt_o,
  output logic [RT_W-1:0]  rt_d_o,
  output logic             drop_o
);
  logic [CFG_W-1:0] cfg_q, cfg_d, merged, sel;
  logic [RT_W-1:0]  req_rt, eff_old, eff_new;
  logic             new_msgm;

  always_comb begin
    sel    = wmask_i & WRITABLE;
    merged = (cfg_q & ~sel) | (wdata_i & sel);
    req_rt = merged[RT_HI:RT_LO];
    if (req_rt != '0 && !cfg_q[PERMIT_LO + int'(req_rt)])
      merged[RT_HI:RT_LO] = '0;
    cfg_d    = we_i ? merged : cfg_q;
    new_msgm = merged[B_MSGEN] & merged[B_MSGCAP];
    eff_old  = msgm_o ? '0 : rt_o;
    eff_new  = new_msgm ? '0 : merged[RT_HI:RT_LO];
    drop_o   = we_i & (!merged[B_ENABLE] | new_msgm | !merged[B_LEVEL] |
                       (eff_new != eff_old));
  end

  always_ff @(posedge clk) begin
    if (rst) cfg_q <= cfg_reset(NUM_LINES);
    else     cfg_q <= cfg_d;
  end

  assign cfg_o  = cfg_q;
  assign en_o   = cfg_q[B_ENABLE];
  assign lvl_o  = cfg_q[B_LEVEL];
  assign msgm_o = cfg_q[B_MSGEN] & cfg_q[B_MSGCAP];
  assign rt_o   = cfg_q[RT_HI:RT_LO];
  assign rt_d_o = cfg_d[RT_HI:RT_LO];

  assert_route_permitted_R8: assert property (@(posedge clk) disable iff (rst)
    (rt_o != '0) |-> cfg_q[PERMIT_LO + int'(rt_o)]);

  assert_ro_mask_kept_R11: assert property (@(posedge clk) disable iff (rst)
    we_i |=> $stable(cfg_q[CFG_W-1:PERMIT_LO]) && cfg_q[B_MSGCAP] && cfg_q[B_PERCAP]);
endmodule

// File: rtl/tir_deliver.sv
module tir_deliver
  import tir_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             match_i,
  input  logic             en_i,
  input  logic             lvl_i,
  input  logic             msgm_i,
  input  logic [RT_W-1:0]  rt_i,
  input  logic             drop_i,
  input  logic             sw_clr_i,
  input  logic             msg_we_i,
  input  logic [CFG_W-1:0] msg_wdata_i,
  input  logic [CFG_W-1:0] msg_wmask_i,
  output logic             edge_d_o,
  output logic [RT_W-1:0]  edge_rt_o,
  output logic             status_d_o,
  output logic             status_o,
  output logic             msg_valid_o,
  output logic [31:0]      msg_addr_o,
  output logic [31:0]      msg_data_o
);
  logic             status_q, fire, msg_fire, line_fire, lvl_set;
  logic [CFG_W-1:0] msg_q;

  always_comb begin
    fire       = match_i & en_i & ~status_q;
    msg_fire   = fire & msgm_i;
    line_fire  = fire & ~msgm_i & (rt_i != '0);
    lvl_set    = line_fire & lvl_i;
    edge_d_o   = line_fire & ~lvl_i;
    edge_rt_o  = rt_i;
    status_d_o = (status_q | lvl_set) & ~drop_i & ~sw_clr_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q    <= 1'b0;
      msg_q       <= '0;
      msg_valid_o <= 1'b0;
      msg_addr_o  <= '0;
      msg_data_o  <= '0;
    end else begin
      status_q    <= status_d_o;
      msg_valid_o <= msg_fire;
      msg_addr_o  <= msg_fire ? msg_q[63:32] : 32'h0;
      msg_data_o  <= msg_fire ? msg_q[31:0]  : 32'h0;
      if (msg_we_i) msg_q <= (msg_q & ~msg_wmask_i) | (msg_wdata_i & msg_wmask_i);
    end
  end

  assign status_o = status_q;

  assert_quiet_when_disabled_R2: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> !msg_valid_o);

  assert_status_needs_level_R7: assert property (@(posedge clk) disable iff (rst)
    status_q |-> (lvl_i && en_i && !msgm_i && rt_i != '0));

  assert_msg_follows_match_R4: assert property (@(posedge clk) disable iff (rst)
    msg_valid_o |-> $past(match_i && en_i && msgm_i));

  assert_sw_clear_wins_R10: assert property (@(posedge clk) disable iff (rst)
    sw_clr_i |=> !status_q);
endmodule

// File: rtl/tir_line_merge.sv
module tir_line_merge
  import tir_pkg::*;
#(
  parameter int NUM_CH    = 3,
  parameter int NUM_LINES = 24
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NUM_CH-1:0]      edge_i,
  input  logic [NUM_CH*RT_W-1:0] edge_rt_i,
  input  logic [NUM_CH-1:0]      lvl_i,
  input  logic [NUM_CH*RT_W-1:0] lvl_rt_i,
  output logic [NUM_LINES-1:0]   line_o
);
  logic [NUM_LINES-1:0] line_d;

  always_comb begin
    line_d = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      for (int k = 0; k < NUM_LINES; k++) begin
        if (edge_i[c] && int'(edge_rt_i[c*RT_W +: RT_W]) == k) line_d[k] = 1'b1;
        if (lvl_i[c]  && int'(lvl_rt_i[c*RT_W +: RT_W])  == k) line_d[k] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) line_o <= '0;
    else     line_o <= line_d;
  end

  assert_line_zero_unrouted_R5: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> !line_o[0]);
endmodule

// File: rtl/timer_irq_router.sv
module timer_irq_router
  import tir_pkg::*;
#(
  parameter int NUM_CH    = 3,
  parameter int NUM_LINES = 24
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_CH-1:0]     match_i,
  input  logic [NUM_CH-1:0]     cfg_we_i,
  input  logic [63:0]           cfg_wdata_i,
  input  logic [63:0]           cfg_wmask_i,
  input  logic [NUM_CH-1:0]     msg_we_i,
  input  logic [63:0]           msg_wdata_i,
  input  logic [63:0]           msg_wmask_i,
  input  logic                  sts_we_i,
  input  logic [NUM_CH-1:0]     sts_wdata_i,
  output logic [NUM_LINES-1:0]  line_o,
  output logic [NUM_CH-1:0]     status_o,
  output logic [NUM_CH*64-1:0]  cfg_o,
  output logic [NUM_CH-1:0]     msg_valid_o,
  output logic [NUM_CH*32-1:0]  msg_addr_o,
  output logic [NUM_CH*32-1:0]  msg_data_o
);
  logic [NUM_CH-1:0]      edge_d, status_d;
  logic [NUM_CH*RT_W-1:0] edge_rt, lvl_rt;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic            en, lvl, msgm, drop;
    logic [RT_W-1:0] rt, rt_d;

    tir_cfg_reg #(.NUM_LINES(NUM_LINES)) u_cfg (
      .clk(clk), .rst(rst), .we_i(cfg_we_i[c]),
      .wdata_i(cfg_wdata_i), .wmask_i(cfg_wmask_i),
      .cfg_o(cfg_o[c*64 +: 64]), .en_o(en), .lvl_o(lvl), .msgm_o(msgm),
      .rt_o(rt), .rt_d_o(rt_d), .drop_o(drop)
    );

    tir_deliver u_dlv (
      .clk(clk), .rst(rst), .match_i(match_i[c]),
      .en_i(en), .lvl_i(lvl), .msgm_i(msgm), .rt_i(rt),
      .drop_i(drop), .sw_clr_i(sts_we_i & sts_wdata_i[c]),
      .msg_we_i(msg_we_i[c]), .msg_wdata_i(msg_wdata_i), .msg_wmask_i(msg_wmask_i),
      .edge_d_o(edge_d[c]), .edge_rt_o(edge_rt[c*RT_W +: RT_W]),
      .status_d_o(status_d[c]), .status_o(status_o[c]),
      .msg_valid_o(msg_valid_o[c]),
      .msg_addr_o(msg_addr_o[c*32 +: 32]), .msg_data_o(msg_data_o[c*32 +: 32])
    );

    assign lvl_rt[c*RT_W +: RT_W] = rt_d;
  end

  tir_line_merge #(.NUM_CH(NUM_CH), .NUM_LINES(NUM_LINES)) u_merge (
    .clk(clk), .rst(rst), .edge_i(edge_d), .edge_rt_i(edge_rt),
    .lvl_i(status_d), .lvl_rt_i(lvl_rt), .line_o(line_o)
  );
endmodule

// File: tb/timer_irq_router_tb.sv
module timer_irq_router_tb;
  localparam int NC = 3;
  localparam int NL = 24;
  localparam logic [63:0] WR = 64'h7E4E;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NC-1:0] match_i = '0, cfg_we_i = '0, msg_we_i = '0, sts_wdata_i = '0;
  logic [63:0] cfg_wdata_i = '0, cfg_wmask_i = '0, msg_wdata_i = '0, msg_wmask_i = '0;
  logic sts_we_i = 1'b0;
  logic [NL-1:0] line_o;
  logic [NC-1:0] status_o, msg_valid_o;
  logic [NC*64-1:0] cfg_o;
  logic [NC*32-1:0] msg_addr_o, msg_data_o;

  always #10 clk = ~clk;

  timer_irq_router #(.NUM_CH(NC), .NUM_LINES(NL)) u_dut (
    .clk(clk), .rst(rst), .match_i(match_i), .cfg_we_i(cfg_we_i),
    .cfg_wdata_i(cfg_wdata_i), .cfg_wmask_i(cfg_wmask_i), .msg_we_i(msg_we_i),
    .msg_wdata_i(msg_wdata_i), .msg_wmask_i(msg_wmask_i), .sts_we_i(sts_we_i),
    .sts_wdata_i(sts_wdata_i), .line_o(line_o), .status_o(status_o), .cfg_o(cfg_o),
    .msg_valid_o(msg_valid_o), .msg_addr_o(msg_addr_o), .msg_data_o(msg_data_o)
  );

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [63:0] m_cfg [NC];
  logic [63:0] m_msg [NC];
  logic        m_sts [NC];
  logic [NL-1:0] m_line;
  logic        m_mv [NC];
  logic [31:0] m_ma [NC], m_md [NC];

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int c = 0; c < NC; c++) begin
      m_cfg[c] = 64'h00F00000_00008010;
      m_msg[c] = '0; m_sts[c] = 1'b0; m_mv[c] = 1'b0; m_ma[c] = '0; m_md[c] = '0;
    end
    m_line = '0;
  endtask

  task automatic model_cycle();
    logic [NL-1:0] ln;
    ln = '0;
    for (int c = 0; c < NC; c++) begin
      logic [63:0] old, nw, wm;
      bit en, lvl, mm, fire, set, drop, nmm;
      int rt, nrt, effo, effn;
      old = m_cfg[c];
      en = old[2]; lvl = old[1]; mm = old[14] && old[15]; rt = int'(old[13:9]);
      fire = match_i[c] && en && !m_sts[c];
      m_mv[c] = 1'b0; m_ma[c] = '0; m_md[c] = '0; set = 0; drop = 0;
      if (fire) begin
        if (mm) begin
          m_mv[c] = 1'b1; m_ma[c] = m_msg[c][63:32]; m_md[c] = m_msg[c][31:0];
        end else if (rt != 0) begin
          if (lvl) set = 1; else ln[rt] = 1'b1;
        end
      end
      if (cfg_we_i[c]) begin
        wm = cfg_wmask_i & WR;
        nw = (old & ~wm) | (cfg_wdata_i & wm);
        nrt = int'(nw[13:9]);
        if (nrt != 0 && !nw[32+nrt]) begin nw[13:9] = '0; nrt = 0; end
        nmm = nw[14] && nw[15];
        effo = mm ? 0 : rt;
        effn = nmm ? 0 : nrt;
        drop = !nw[2] || nmm || !nw[1] || (effn != effo);
        m_cfg[c] = nw;
      end
      if (msg_we_i[c]) m_msg[c] = (m_msg[c] & ~msg_wmask_i) | (msg_wdata_i & msg_wmask_i);
      m_sts[c] = (m_sts[c] || set) && !drop && !(sts_we_i && sts_wdata_i[c]);
      if (m_sts[c]) ln[int'(m_cfg[c][13:9])] = 1'b1;
    end
    m_line = ln;
  endtask

  task automatic compare_all(input string req);
    chk(req, "line_o", 64'(line_o), 64'(m_line));
    for (int c = 0; c < NC; c++) begin
      chk(req, "status_o", 64'(status_o[c]), 64'(m_sts[c]));
      chk(req, "cfg_o", cfg_o[c*64 +: 64], m_cfg[c]);
      chk(req, "msg_valid_o", 64'(msg_valid_o[c]), 64'(m_mv[c]));
      chk(req, "msg_addr_o", 64'(msg_addr_o[c*32 +: 32]), 64'(m_ma[c]));
      chk(req, "msg_data_o", 64'(msg_data_o[c*32 +: 32]), 64'(m_md[c]));
    end
  endtask

  task automatic step(input string req);
    model_cycle();
    @(posedge clk);
    @(negedge clk);
    compare_all(req);
    match_i = '0; cfg_we_i = '0; msg_we_i = '0; sts_we_i = 1'b0; sts_wdata_i = '0;
    cfg_wdata_i = '0; cfg_wmask_i = '0; msg_wdata_i = '0; msg_wmask_i = '0;
  endtask

  task automatic wcfg(input int c, input logic [63:0] d);
    cfg_we_i[c] = 1'b1; cfg_wdata_i = d; cfg_wmask_i = '1;
  endtask

  initial begin
    for (int i = 0; i < 20000 && !done; i++) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    compare_all("R1");
    chk("R1", "cfg reset ch0", cfg_o[63:0], 64'h00F00000_00008010);
    chk("R1", "lines after reset", 64'(line_o), 64'h0);

    // R6 edge pulse on line 21, and R11 readback of merged config
    wcfg(0, 64'h2A04); step("R11");
    chk("R11", "cfg ch0 edge route21", cfg_o[63:0], 64'h00F00000_0000AA14);
    match_i[0] = 1'b1; step("R6");
    chk("R6", "edge pulse line21", 64'(line_o), 64'd1 << 21);
    step("R6");
    chk("R6", "edge pulse gone", 64'(line_o), 64'h0);

    // R8 unpermitted route 5 reset to 0; R5 no line for route 0
    wcfg(0, 64'h0A04); step("R8");
    chk("R8", "route reset to 0", cfg_o[63:0], 64'h00F00000_00008014);
    match_i[0] = 1'b1; step("R5");
    chk("R5", "route 0 drives nothing", 64'(line_o), 64'h0);

    // R2 disabled channel
    wcfg(0, 64'h2A00); step("R2");
    match_i[0] = 1'b1; step("R2");
    chk("R2", "disabled no line", 64'(line_o), 64'h0);

    // R7 level on line 22, R3 repeat match, R10 software clear
    wcfg(1, 64'h2C06); step("R7");
    match_i[1] = 1'b1; step("R7");
    chk("R7", "level status", 64'(status_o), 64'b010);
    chk("R7", "level line22", 64'(line_o), 64'd1 << 22);
    repeat (3) step("R7");
    chk("R7", "level held", 64'(line_o), 64'd1 << 22);
    match_i[1] = 1'b1; step("R3");
    chk("R3", "no further effect", 64'(line_o), 64'd1 << 22);
    sts_we_i = 1'b1; sts_wdata_i = 3'b101; step("R10");
    chk("R10", "zero bits kept", 64'(status_o), 64'b010);
    sts_we_i = 1'b1; sts_wdata_i = 3'b010; step("R10");
    chk("R10", "status cleared", 64'(status_o), 64'h0);
    chk("R10", "line dropped", 64'(line_o), 64'h0);

    // R9 automatic withdrawal
    match_i[1] = 1'b1; step("R9");
    wcfg(1, 64'h2E06); step("R9");
    chk("R9", "route change clears", 64'(status_o), 64'h0);
    match_i[1] = 1'b1; step("R9");
    wcfg(1, 64'h2E02); step("R9");
    chk("R9", "disable clears", 64'(status_o), 64'h0);
    wcfg(1, 64'h2E06); step("R9");
    match_i[1] = 1'b1; step("R9");
    wcfg(1, 64'h2E04); step("R9");
    chk("R9", "edge clears", 64'(status_o), 64'h0);
    wcfg(1, 64'h2E06); step("R9");
    match_i[1] = 1'b1; step("R9");
    wcfg(1, 64'h2E0E); step("R9");
    chk("R9", "unrelated write keeps", 64'(status_o), 64'b010);
    wcfg(1, 64'h6E06); step("R9");
    chk("R9", "message mode clears", 64'(status_o), 64'h0);
    chk("R9", "line dropped", 64'(line_o), 64'h0);

    // R4 message delivery
    msg_we_i[2] = 1'b1; msg_wdata_i = 64'hFEE00000_00000041; msg_wmask_i = '1; step("R4");
    wcfg(2, 64'h6804); step("R4");
    match_i[2] = 1'b1; step("R4");
    chk("R4", "msg valid", 64'(msg_valid_o), 64'b100);
    chk("R4", "msg addr", 64'(msg_addr_o[95:64]), 64'hFEE00000);
    chk("R4", "msg data", 64'(msg_data_o[95:64]), 64'h41);
    chk("R5", "message mode no line", 64'(line_o), 64'h0);
    step("R4");
    chk("R4", "msg one cycle", 64'(msg_valid_o), 64'h0);
    msg_we_i[2] = 1'b1; msg_wdata_i = '1; msg_wmask_i = 64'hFFFFFFFF_00000000; step("R4");
    match_i[2] = 1'b1; step("R4");
    chk("R4", "masked msg addr", 64'(msg_addr_o[95:64]), 64'hFFFFFFFF);
    chk("R4", "masked msg data", 64'(msg_data_o[95:64]), 64'h41);

    // R11 read-only and masked bits
    wcfg(0, '1); step("R11");
    chk("R11", "all-ones write", cfg_o[63:0], 64'h00F00000_0000C05E);
    cfg_we_i[0] = 1'b1; cfg_wdata_i = '0; cfg_wmask_i = 64'hFFFFFFFF_FFFF0000; step("R11");
    chk("R11", "masked-off bits kept", cfg_o[63:0], 64'h00F00000_0000C05E);

    // R12 clear wins over same-cycle level match
    wcfg(1, 64'h2C06); step("R12");
    match_i[1] = 1'b1; sts_we_i = 1'b1; sts_wdata_i = 3'b010; step("R12");
    chk("R12", "clear wins", 64'(status_o), 64'h0);
    chk("R12", "no level line", 64'(line_o), 64'h0);

    // R5/R6/R7 two channels together, then level with route 0
    wcfg(0, 64'h2804); step("R6");
    match_i = 3'b011; step("R7");
    chk("R7", "edge and level lines", 64'(line_o), (64'd1 << 20) | (64'd1 << 22));
    step("R6");
    chk("R6", "only level remains", 64'(line_o), 64'd1 << 22);
    wcfg(1, 64'h0006); step("R9");
    match_i[1] = 1'b1; step("R5");
    chk("R5", "route 0 level nothing", 64'(status_o), 64'h0);
    step("R5");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule